// File: doc/BRIEF.md
# Transmit Descriptor-Ring DMA Engine

This block moves outgoing frames from memory to a byte stream by walking a linked chain of transmit descriptors. Each descriptor is four 32-bit words: a control word, the buffer start address, a status/length word and the address of the next descriptor. Software fills descriptors, hands them to the engine by setting the owner bit, and then strobes a transmit-demand input. The engine processes descriptors one after another. For each one it streams the frame bytes out and can zero-pad a short frame. It then writes the descriptor back with ownership returned and a completion status, and follows the next pointer. It stops when it meets a descriptor it does not own.

The engine uses a single 32-bit memory port that carries one word access at a time. Frame bytes leave on a byte stream with a valid/ready handshake and a last marker. Single-cycle event pulses go to an interrupt block, and the current descriptor and buffer addresses are visible as outputs. The line side and CRC generation are not part of this block.

Top module: `tdma_tx`

## Requirements
- R1: After reset the current descriptor address is 0xFFFFFFFC, the current buffer address is 0, and `busy_o`, `mem_req_o` and `tx_valid_o` are low.
- R2: A rising edge of `tx_en_i` loads the current descriptor address from `start_addr_i` and starts no memory access.
- R3: A `demand_i` pulse while `tx_en_i` is high starts descriptor processing. A pulse while `tx_en_i` is low has no effect: no memory request is made.
- R4: A descriptor is read as four words at offsets 0, 4, 8 and 12, in that order. Bit 31 of word 0 is the owner bit, bit 2 is interrupt-enable, bit 0 is pad-enable, and bits 15:0 of word 2 are the frame length in bytes.
- R5: If the owner bit is clear, the engine pulses `evt_unavail_o` and stops. It writes nothing, and the current descriptor address keeps pointing at that descriptor.
- R6: An error response on any descriptor word read pulses `evt_berr_o` and stops the engine without writeback.
- R7: For an owned descriptor, `cur_buf_o` takes word 1 and the frame is streamed from that word-aligned buffer, low byte of each word first. `tx_last_o` marks only the final byte. A zero-length frame without padding emits no bytes.
- R8: With pad-enable set and a length below 60, the bytes past the length are sent as zeros up to 60 bytes in total.
- R9: Writeback first writes word 2 as the length in bits 15:0 with bits 31:16 cleared, except bit 19 (frame sent without buffer error) and bit 16 (`sum_irq_i` was high when writeback began). It then writes word 0 with bit 31 cleared. After that the next descriptor address is taken and read at once.
- R10: `evt_done_o` pulses after a descriptor's writeback only when its interrupt-enable bit is set and the frame was sent without buffer error.
- R11: An error response on a buffer read pulses `evt_berr_o` and stops the stream, with no further bytes and no last marker. The descriptor is still written back without bit 19, and the next pointer is still followed.
- R12: A falling edge of `tx_en_i` pulses `evt_halt_o`, drops any queued frame bytes and returns the engine to idle. A memory access that is already outstanding is allowed to finish and is then discarded.
- R13: `mem_req_o` stays high with a stable address, direction and write data until `mem_rsp_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_en_i | input | 1 | Transmit enable level |
| start_addr_i | input | 32 | First descriptor address, loaded on enable rising edge |
| demand_i | input | 1 | Transmit-demand strobe |
| sum_irq_i | input | 1 | Transmit summary interrupt level from the interrupt block |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Word byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_rsp_i | input | 1 | Access complete |
| mem_rdata_i | input | 32 | Read data, valid with `mem_rsp_i` |
| mem_err_i | input | 1 | Access failed, valid with `mem_rsp_i` |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_last_o | output | 1 | Final byte of frame |
| tx_ready_i | input | 1 | Sink accepts the byte |
| evt_done_o | output | 1 | Transmit-complete pulse |
| evt_unavail_o | output | 1 | Descriptor-unavailable pulse |
| evt_berr_o | output | 1 | Bus-error pulse |
| evt_halt_o | output | 1 | Transmit-halted pulse |
| cur_desc_o | output | 32 | Current descriptor address |
| cur_buf_o | output | 32 | Current buffer address |
| busy_o | output | 1 | Engine is processing descriptors |

## Verification
The dropping of transmit enable can coincide with a memory access that has not yet been answered. The bench provokes this by setting a memory latency of several cycles and pulling `tx_en_i` low while the first descriptor read is pending. The expected outcome is a halt pulse and no unavailable or bus-error pulse from the late response. Memory must receive no write, and `busy_o` and `mem_req_o` must drop once that response arrives. The same collision with the stream is judged by dropping enable while the sink stalls mid-frame and checking that no further bytes appear and no writeback happens.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  typedef enum logic [2:0] {S_IDLE, S_DRD, S_SEND, S_BRD, S_WB} state_e;
  localparam int unsigned OWN_BIT     = 31;
  localparam int unsigned INTEN_BIT   = 2;
  localparam int unsigned PAD_BIT     = 0;
  localparam int unsigned ST_DONE_BIT = 3;  // word 2 bit 19
  localparam int unsigned ST_IRQ_BIT  = 0;  // word 2 bit 16
endpackage

// File: rtl/tdma_edge.sv
module tdma_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic rise_o,
  output logic fall_o
);
  logic en_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  assign rise_o = en_i & ~en_q;
  assign fall_o = ~en_i & en_q;
endmodule

// File: rtl/tdma_ser.sv
module tdma_ser #(
  parameter int BPW = 4,
  localparam int CW = $clog2(BPW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             load_i,
  input  logic [8*BPW-1:0] word_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic             last_i,
  input  logic             ready_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             empty_o
);
  logic [8*BPW-1:0] sh_q;
  logic [CW-1:0]    left_q;
  logic             last_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      last_q <= 1'b0;
    end else if (flush_i) begin
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= word_i;
      left_q <= cnt_i;
      last_q <= last_i;
    end else if (valid_o && ready_i) begin
      sh_q   <= sh_q >> 8;
      left_q <= left_q - 1'b1;
    end

  assign valid_o = (left_q != '0);
  assign empty_o = (left_q == '0);
  assign data_o  = sh_q[7:0];
  assign last_o  = last_q && (left_q == CW'(1));
endmodule

// File: rtl/tdma_tx.sv
module tdma_tx
  import tdma_pkg::*;
#(
  parameter int          MIN_LEN = 60,
  parameter logic [31:0] RST_PTR = 32'hFFFF_FFFC
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_en_i,
  input  logic [31:0] start_addr_i,
  input  logic        demand_i,
  input  logic        sum_irq_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_rsp_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        mem_err_i,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  output logic        tx_last_o,
  input  logic        tx_ready_i,
  output logic        evt_done_o,
  output logic        evt_unavail_o,
  output logic        evt_berr_o,
  output logic        evt_halt_o,
  output logic [31:0] cur_desc_o,
  output logic [31:0] cur_buf_o,
  output logic        busy_o
);
  localparam int LW  = 16;
  localparam int BPW = 4;
  localparam int CW  = $clog2(BPW + 1);
  localparam logic [LW-1:0] MINL = LW'(MIN_LEN);

  state_e        state_q;
  logic [1:0]    idx_q;
  logic [31:0]   flags_q, next_q, cur_desc_q, cur_buf_q;
  logic [LW-1:0] len_q, pos_q;
  logic          ok_q, irq_q, abort_q;
  logic          evt_done_q, evt_unav_q, evt_berr_q, evt_halt_q;

  logic rise, fall, acc, ser_empty, ser_load, pad_ld, dat_ld, ser_last;
  logic [LW-1:0] total_w, rem_w, avail_w;
  logic [CW-1:0] n_w;
  logic [31:0]   masked_w, ser_word, fl_wb;
  logic [15:0]   sts_w;

  tdma_edge u_edge (.clk_i, .rst_ni, .en_i(tx_en_i), .rise_o(rise), .fall_o(fall));

  always_comb begin
    total_w = (flags_q[PAD_BIT] && len_q < MINL) ? MINL : len_q;
    rem_w   = total_w - pos_q;
    avail_w = len_q - pos_q;
    n_w     = (rem_w >= LW'(BPW)) ? CW'(BPW) : rem_w[CW-1:0];
    for (int b = 0; b < BPW; b++)
      masked_w[b*8 +: 8] = (LW'(b) < avail_w) ? mem_rdata_i[b*8 +: 8] : 8'h00;
  end

  assign acc      = (state_q == S_DRD) || (state_q == S_BRD) || (state_q == S_WB);
  assign pad_ld   = (state_q == S_SEND) && ser_empty && !fall && !abort_q &&
                    (pos_q >= len_q) && (pos_q < total_w);
  assign dat_ld   = (state_q == S_BRD) && mem_rsp_i && !mem_err_i && !abort_q && !fall;
  assign ser_load = pad_ld | dat_ld;
  assign ser_word = dat_ld ? masked_w : '0;
  assign ser_last = ((pos_q + LW'(n_w)) == total_w);

  tdma_ser #(.BPW(BPW)) u_ser (
    .clk_i, .rst_ni, .flush_i(fall), .load_i(ser_load), .word_i(ser_word),
    .cnt_i(n_w), .last_i(ser_last), .ready_i(tx_ready_i),
    .data_o(tx_data_o), .valid_o(tx_valid_o), .last_o(tx_last_o), .empty_o(ser_empty)
  );

  always_comb begin
    sts_w              = '0;
    sts_w[ST_DONE_BIT] = ok_q;
    sts_w[ST_IRQ_BIT]  = irq_q;
    fl_wb              = flags_q;
    fl_wb[OWN_BIT]     = 1'b0;
    mem_we_o           = (state_q == S_WB);
    mem_wdata_o        = (idx_q == 2'd2) ? {sts_w, len_q} : fl_wb;
    unique case (state_q)
      S_BRD:   mem_addr_o = {cur_buf_q[31:2], 2'b00} + {16'b0, pos_q};
      default: mem_addr_o = cur_desc_q + {28'b0, idx_q, 2'b00};
    endcase
  end
  assign mem_req_o = acc;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      flags_q    <= '0;
      next_q     <= '0;
      len_q      <= '0;
      pos_q      <= '0;
      ok_q       <= 1'b0;
      irq_q      <= 1'b0;
      abort_q    <= 1'b0;
      cur_desc_q <= RST_PTR;
      cur_buf_q  <= '0;
      evt_done_q <= 1'b0;
      evt_unav_q <= 1'b0;
      evt_berr_q <= 1'b0;
      evt_halt_q <= 1'b0;
    end else begin
      evt_done_q <= 1'b0;
      evt_unav_q <= 1'b0;
      evt_berr_q <= 1'b0;
      evt_halt_q <= 1'b0;
      if (ser_load) pos_q <= pos_q + LW'(n_w);
      if (fall) begin
        evt_halt_q <= 1'b1;
        if (acc && !mem_rsp_i) abort_q <= 1'b1;
        else begin
          abort_q <= 1'b0;
          state_q <= S_IDLE;
        end
      end else if (abort_q) begin
        if (mem_rsp_i) begin
          abort_q <= 1'b0;
          state_q <= S_IDLE;
        end
      end else begin
        unique case (state_q)
          S_IDLE: if (demand_i && tx_en_i) begin
            state_q <= S_DRD;
            idx_q   <= '0;
          end
          S_DRD: if (mem_rsp_i) begin
            if (mem_err_i) begin
              evt_berr_q <= 1'b1;
              state_q    <= S_IDLE;
            end else begin
              unique case (idx_q)
                2'd0: if (!mem_rdata_i[OWN_BIT]) begin
                        evt_unav_q <= 1'b1;
                        state_q    <= S_IDLE;
                      end else begin
                        flags_q <= mem_rdata_i;
                        idx_q   <= 2'd1;
                      end
                2'd1: begin cur_buf_q <= mem_rdata_i;        idx_q <= 2'd2; end
                2'd2: begin len_q     <= mem_rdata_i[LW-1:0]; idx_q <= 2'd3; end
                default: begin
                  next_q  <= mem_rdata_i;
                  pos_q   <= '0;
                  ok_q    <= 1'b1;
                  state_q <= S_SEND;
                end
              endcase
            end
          end
          S_SEND: if (ser_empty) begin
            if (pos_q >= total_w) begin
              state_q <= S_WB;
              idx_q   <= 2'd2;
              irq_q   <= sum_irq_i;
            end else if (pos_q < len_q) state_q <= S_BRD;
          end
          S_BRD: if (mem_rsp_i) begin
            if (mem_err_i) begin
              evt_berr_q <= 1'b1;
              ok_q       <= 1'b0;
              state_q    <= S_WB;
              idx_q      <= 2'd2;
              irq_q      <= sum_irq_i;
            end else state_q <= S_SEND;
          end
          S_WB: if (mem_rsp_i) begin
            if (mem_err_i) evt_berr_q <= 1'b1;
            if (idx_q == 2'd2) idx_q <= 2'd0;
            else begin
              cur_desc_q <= next_q;
              evt_done_q <= ok_q && flags_q[INTEN_BIT];
              state_q    <= S_DRD;
              idx_q      <= '0;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
      if (rise) cur_desc_q <= start_addr_i;
    end

  assign evt_done_o    = evt_done_q;
  assign evt_unavail_o = evt_unav_q;
  assign evt_berr_o    = evt_berr_q;
  assign evt_halt_o    = evt_halt_q;
  assign cur_desc_o    = cur_desc_q;
  assign cur_buf_o     = cur_buf_q;
  assign busy_o        = (state_q != S_IDLE);
endmodule

// File: rtl/tdma_tx_chk.sv
module tdma_tx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_en_i,
  input logic        mem_req_o,
  input logic        mem_we_o,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        mem_rsp_i,
  input logic        abort_q,
  input logic [7:0]  tx_data_o,
  input logic        tx_valid_o,
  input logic        tx_last_o,
  input logic        tx_ready_i,
  input logic        evt_done_o,
  input logic        evt_unavail_o,
  input logic        evt_berr_o,
  input logic [31:0] cur_desc_o,
  input logic        busy_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_i && !abort_q |=> mem_req_o && $stable(mem_addr_o) &&
    $stable(mem_we_o) && $stable(mem_wdata_o)); // R13
  AST_HALT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({evt_unavail_o, evt_berr_o})); // R6
  AST_UNAVAIL_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_unavail_o |-> !busy_o && $stable(cur_desc_o)); // R5
  AST_STREAM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i && tx_en_i |=> tx_valid_o && $stable(tx_data_o) &&
    $stable(tx_last_o)); // R7
  AST_STREAM_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> busy_o); // R12
  AST_DONE_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_done_o |-> $past(mem_req_o && mem_we_o && mem_rsp_i)); // R10
endmodule

bind tdma_tx tdma_tx_chk u_chk (.*);

// File: tb/tb_tdma_tx.sv
`timescale 1ns/1ps
module tb_tdma_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, demand = 0, sum_irq = 0, tx_ready = 0;
  logic [31:0] start_addr = '0;
  logic mem_req, mem_we, mem_rsp = 0, mem_err = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, ev_done, ev_unav, ev_berr, ev_halt, busy;
  logic [31:0] cur_desc, cur_buf;

  always #2 clk = ~clk;

  tdma_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .start_addr_i(start_addr),
    .demand_i(demand), .sum_irq_i(sum_irq), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rsp_i(mem_rsp),
    .mem_rdata_i(mem_rdata), .mem_err_i(mem_err), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_last_o(tx_last), .tx_ready_i(tx_ready),
    .evt_done_o(ev_done), .evt_unavail_o(ev_unav), .evt_berr_o(ev_berr),
    .evt_halt_o(ev_halt), .cur_desc_o(cur_desc), .cur_buf_o(cur_buf), .busy_o(busy)
  );

  int checks = 0, failures = 0;
  logic [31:0] mem [0:255];
  int lat = 0, wcnt = 0, rdy_mode = 0, cyc = 0;
  bit err_en = 0;
  logic [31:0] err_addr = '0;
  int n_done, n_unav, n_berr, n_halt, n_req, cap_n, n_last, wn;
  logic [7:0] cap_d [0:255];
  bit cap_l [0:255];
  logic [31:0] wlog [0:15];

  function automatic logic [7:0] pat(int a);
    return 8'(a * 7 + 3);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model, stream sink, event monitors
  always @(negedge clk) begin
    bit prev;
    cyc++;
    if (!rst_n) begin
      mem_rsp = 0; mem_err = 0; wcnt = 0;
    end else begin
      prev = mem_rsp;
      mem_rsp = 0; mem_err = 0;
      if (prev) wcnt = 0;
      if (mem_req) begin
        n_req++;
        if (wcnt >= lat) begin
          mem_rsp = 1;
          mem_err = err_en && (mem_addr == err_addr);
          if (!mem_err) begin
            if (mem_we) begin
              mem[mem_addr[9:2]] = mem_wdata;
              if (wn < 16) wlog[wn] = mem_addr;
              wn++;
            end else mem_rdata = mem[mem_addr[9:2]];
          end
        end else wcnt++;
      end
      case (rdy_mode)
        0: tx_ready = 1;
        1: tx_ready = cyc[0];
        default: tx_ready = 0;
      endcase
      if (tx_valid && tx_ready) begin
        cap_d[cap_n[7:0]] = tx_data;
        cap_l[cap_n[7:0]] = tx_last;
        if (tx_last) n_last++;
        cap_n++;
      end
      if (ev_done) n_done++;
      if (ev_unav) n_unav++;
      if (ev_berr) n_berr++;
      if (ev_halt) n_halt++;
    end
  end

  task automatic clear_counts();
    n_done = 0; n_unav = 0; n_berr = 0; n_halt = 0; n_req = 0;
    cap_n = 0; n_last = 0; wn = 0;
  endtask

  task automatic put_desc(int a, logic [31:0] fl, logic [31:0] bf, int len, logic [31:0] nx);
    mem[a/4]     = fl;
    mem[a/4 + 1] = bf;
    mem[a/4 + 2] = {16'hABCD, 16'(len)};
    mem[a/4 + 3] = nx;
  endtask

  task automatic restart(logic [31:0] a);
    tx_en = 0;
    repeat (3) @(negedge clk);
    clear_counts();
    start_addr = a;
    tx_en = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic kick_wait();
    int t;
    t = 0;
    demand = 1;
    @(negedge clk);
    demand = 0;
    while (busy && t < 5000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_bytes(string req, int base, int len, int total);
    int bad;
    bad = -1;
    for (int i = 0; i < cap_n && i < 256; i++)
      if (cap_d[i] != ((i < len) ? pat(base + i) : 8'h00)) bad = i;
    chk(cap_n == total, req, "byte count", cap_n, total);
    chk(bad < 0, req, "byte values (bad index)", bad, -1);
    if (total > 0)
      chk(n_last == 1 && cap_l[total - 1], req, "last marker count", n_last, 1);
  endtask

  initial begin
    int lens [9] = '{0, 1, 3, 4, 5, 59, 60, 61, 70};
    for (int w = 0; w < 256; w++) mem[w] = '0;
    for (int w = 64; w < 256; w++)
      mem[w] = {pat(4*w+3), pat(4*w+2), pat(4*w+1), pat(4*w)};
    clear_counts();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cur_desc == 32'hFFFF_FFFC, "R1", "cur_desc", cur_desc, 32'hFFFF_FFFC);
    chk(cur_buf == 0 && !busy && !mem_req && !tx_valid, "R1", "idle outputs",
        {cur_buf[3:0], busy, mem_req, tx_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R3 demand while disabled
    demand = 1; @(negedge clk); demand = 0;
    repeat (5) @(negedge clk);
    chk(n_req == 0 && !busy, "R3", "requests while disabled", n_req, 0);
    // R2 rising edge loads pointer, no access
    restart(32'h0000_0040);
    repeat (4) @(negedge clk);
    chk(cur_desc == 32'h40, "R2", "pointer load", cur_desc, 32'h40);
    chk(n_req == 0, "R2", "no access after rise", n_req, 0);

    // R7/R8/R9/R10 sweep over length, pad, interrupt-enable, latency, sink pacing
    for (int li = 0; li < 9; li++)
      for (int p = 0; p < 2; p++) begin
        int len, tot;
        logic [31:0] fl;
        len = lens[li];
        tot = (p == 1 && len < 60) ? 60 : len;
        fl = 32'h8000_0000 | (li % 2 ? 32'h4 : 0) | (p ? 32'h1 : 0);
        lat = ((li + p) % 2) * 2;
        rdy_mode = li % 2;
        put_desc(0, fl, 32'h200, len, 32'h10);
        put_desc(16, 0, 32'h300, 4, 32'h20);
        restart(0);
        kick_wait();
        check_bytes(p ? "R8" : "R7", 32'h200, len, tot);
        chk(cur_buf == 32'h200, "R7", "cur_buf", cur_buf, 32'h200);
        chk(mem[2] == {16'h0008, 16'(len)}, "R9", "status word", mem[2], {16'h0008, 16'(len)});
        chk(mem[0] == (fl & 32'h7FFF_FFFF), "R9", "owner returned", mem[0], fl & 32'h7FFF_FFFF);
        chk(wn == 2 && wlog[0] == 32'h8 && wlog[1] == 32'h0, "R9", "writeback order",
            {wlog[0][7:0], wlog[1][7:0]}, 16'h0800);
        chk(n_done == li % 2, "R10", "done pulses", n_done, li % 2);
        chk(n_unav == 1 && cur_desc == 32'h10, "R5", "halt at unowned next",
            cur_desc, 32'h10);
      end

    // R4/R9 chain of three descriptors, summary interrupt high
    lat = 1; rdy_mode = 0; sum_irq = 1;
    put_desc(32'h00, 32'h8000_0004, 32'h200, 5, 32'h30);
    put_desc(32'h30, 32'h8000_0004, 32'h280, 8, 32'h60);
    put_desc(32'h60, 32'h8000_0004, 32'h300, 2, 32'h90);
    put_desc(32'h90, 32'h0, 32'h300, 2, 32'h0);
    restart(0);
    kick_wait();
    begin
      int bad;
      bad = -1;
      for (int i = 0; i < 15; i++)
        if (cap_d[i] != (i < 5 ? pat(32'h200 + i) : i < 13 ? pat(32'h280 + i - 5)
                                                  : pat(32'h300 + i - 13))) bad = i;
      chk(cap_n == 15 && bad < 0, "R4", "chain bytes (bad index)", bad, -1);
    end
    chk(n_last == 3 && n_done == 3, "R9", "three frames done", n_done, 3);
    chk(mem[32'h60/4 + 2] == 32'h0009_0002, "R9", "status with irq bit",
        mem[32'h60/4 + 2], 32'h0009_0002);
    chk(cur_desc == 32'h90 && n_unav == 1, "R4", "chain end pointer", cur_desc, 32'h90);
    sum_irq = 0;

    // R5 first descriptor unowned
    put_desc(0, 32'h0000_0005, 32'h200, 8, 32'h10);
    restart(0);
    kick_wait();
    chk(n_unav == 1 && wn == 0 && cap_n == 0, "R5", "unowned stop", wn, 0);
    chk(cur_desc == 0, "R5", "pointer not advanced", cur_desc, 0);

    // R6 descriptor word read error
    put_desc(0, 32'h8000_0004, 32'h200, 8, 32'h10);
    err_en = 1; err_addr = 32'h4;
    restart(0);
    kick_wait();
    chk(n_berr == 1 && !busy && cap_n == 0 && wn == 0, "R6", "desc error stop", n_berr, 1);
    chk(mem[0][31] && cur_desc == 0, "R6", "no writeback", cur_desc, 0);

    // R11 buffer read error on second word
    put_desc(0, 32'h8000_0004, 32'h200, 12, 32'h10);
    put_desc(16, 0, 32'h300, 4, 32'h20);
    err_addr = 32'h204;
    restart(0);
    kick_wait();
    err_en = 0;
    chk(cap_n == 4 && n_last == 0, "R11", "truncated stream", cap_n, 4);
    chk(n_berr == 1 && n_done == 0, "R11", "berr without done", n_berr, 1);
    chk(mem[2] == 32'h0000_000C, "R11", "status without sent bit", mem[2], 32'hC);
    chk(!mem[0][31] && cur_desc == 32'h10, "R11", "pointer advanced", cur_desc, 32'h10);

    // R12 enable drop while sink stalls mid-frame
    put_desc(0, 32'h8000_0001, 32'h200, 60, 32'h10);
    rdy_mode = 2; lat = 0;
    restart(0);
    demand = 1; @(negedge clk); demand = 0;
    repeat (12) @(negedge clk);
    chk(tx_valid, "R12", "stalled byte pending", tx_valid, 1);
    tx_en = 0;
    repeat (4) @(negedge clk);
    chk(n_halt == 1 && !busy && !tx_valid, "R12", "halt on fall", n_halt, 1);
    chk(wn == 0 && mem[0][31], "R12", "no writeback after halt", wn, 0);
    rdy_mode = 0;

    // R12/R13 enable drop with a descriptor read outstanding
    lat = 6;
    restart(0);
    demand = 1; @(negedge clk); demand = 0;
    repeat (2) @(negedge clk);
    chk(mem_req, "R13", "request pending", mem_req, 1);
    tx_en = 0;
    repeat (12) @(negedge clk);
    chk(n_halt == 1 && n_unav == 0 && n_berr == 0, "R12", "only halt event", n_halt, 1);
    chk(!busy && !mem_req && wn == 0, "R13", "access retired", mem_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog R3 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule